// File: doc/BRIEF.md
# Latched-Read Timestamp Counter

This block keeps a free-running 40-bit time base for a chip. The count advances by one on each clock cycle in which an external tick strobe is high and the run enable is set. The nominal tick rate is 983040 Hz. The prescaler that makes that strobe is outside this block. The counter never raises an interrupt. Software reads it through two registers on a simple read/write register bus. One register returns the low 32 bits. The other returns a shadowed copy of the top 8 bits, plus the run enable.

A read of the low word captures the top byte into the shadow in the same cycle. The low word and the shadow therefore come from the same count. A later read of the high register gives the other half of a coherent 40-bit value, even if a carry out of the low word happens between the two reads. The run enable sits one bit above the shadow byte in the high register. Software both sets and reads it there. Read data comes back one cycle after the read request, qualified by a valid strobe.

Top module: `tsc_timebase`

## Requirements
- R1: After reset the count, the shadow byte and the run enable are all zero, and bus_rvalid and bus_rdata are low.
- R2: The count increases by one at a clock edge where tick and the run enable are both high. At every other edge it keeps its value, so clearing the enable freezes the count without resetting it.
- R3: When the count is all ones, one more counted tick makes it zero.
- R4: A read asserts bus_rvalid for exactly the next cycle. bus_rdata carries the read result in that cycle and is zero whenever bus_rvalid is low. A read at offset 0x60 returns the low LO_W bits of the count, zero-extended.
- R5: A read at offset 0x60 loads the shadow with the top HI_W bits of the count. Both halves are taken from the count held before that edge, even when a tick in the same cycle carries into the top byte.
- R6: A read at offset 0x64 returns the shadow in bits [7:0] and the run enable in bit 8. All higher bits are zero.
- R7: A write at offset 0x64 sets the run enable to wdata bit 8. Bits [7:0] of that write leave the shadow unchanged.
- R8: A write at offset 0x60 has no effect on the count, the shadow or the run enable.
- R9: A tick in the same cycle as an enable write is counted or not according to the enable held before that write.
- R10: A read at any other offset returns zero with bus_rvalid high and leaves the shadow unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| tick | input | 1 | Count strobe, one cycle per time-base tick |
| bus_rd | input | 1 | Read request; takes priority over bus_wr |
| bus_wr | input | 1 | Write request |
| bus_addr | input | ADDR_W (8) | Byte offset of the access |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | High for one cycle after each read |

## Verification
The collision that matters most is a low-word read in the same cycle as a tick that carries out of the low word. The bench uses a narrow low word so that this carry comes within a few dozen ticks. It steps the count to the all-ones low pattern, then issues the read together with the carrying tick. The read must return all ones, and the following high read must return the old top byte. Only the next low and high reads may show the new values. A second collision, an enable write together with a tick, is judged from the low word read back afterwards.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

  // One decoded bus action per cycle; reads win over writes.
  typedef enum logic [2:0] {
    ACC_IDLE    = 3'd0,
    ACC_RD_LO   = 3'd1,
    ACC_RD_HI   = 3'd2,
    ACC_RD_NONE = 3'd3,
    ACC_WR_HI   = 3'd4,
    ACC_WR_NONE = 3'd5
  } acc_e;

endpackage

// File: rtl/tsc_reset_sync.sv
module tsc_reset_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= sync_d;
  end

  assign rst_n = sync_q[1];
endmodule

// File: rtl/tsc_counter.sv
module tsc_counter #(
  parameter int CNT_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt_q
);
  logic             step;
  logic [CNT_W-1:0] cnt_d;

  // Wrap to zero falls out of the modulo add.
  always_comb begin
    step  = run & tick;
    cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (step) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tsc_decode.sv
module tsc_decode
  import tsc_pkg::*;
#(
  parameter int                ADDR_W = 8,
  parameter logic [ADDR_W-1:0] LO_OFF = 'h60,
  parameter logic [ADDR_W-1:0] HI_OFF = 'h64
) (
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output acc_e              acc
);
  always_comb begin
    acc = ACC_IDLE;
    if (rd) begin
      if (addr == LO_OFF)      acc = ACC_RD_LO;
      else if (addr == HI_OFF) acc = ACC_RD_HI;
      else                     acc = ACC_RD_NONE;
    end else if (wr) begin
      if (addr == HI_OFF) acc = ACC_WR_HI;
      else                acc = ACC_WR_NONE;
    end
  end
endmodule

// File: rtl/tsc_regs.sv
module tsc_regs
  import tsc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LO_W   = 32,
  parameter int HI_W   = 8,
  localparam int CNT_W = LO_W + HI_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  acc_e              acc,
  input  logic              wr_run,
  input  logic [CNT_W-1:0]  cnt,
  output logic              run_q,
  output logic [HI_W-1:0]   shadow_q,
  output logic [DATA_W-1:0] rdata_q,
  output logic              rvalid_q
);
  logic [DATA_W-1:0] lo_word;
  logic [DATA_W-1:0] hi_word;
  logic              run_d;
  logic [HI_W-1:0]   shadow_d;
  logic [DATA_W-1:0] rdata_d;
  logic              rvalid_d;

  // Zero-extend the low word only when it is narrower than the bus.
  generate
    if (LO_W == DATA_W) begin : g_lo_full
      assign lo_word = cnt[LO_W-1:0];
    end else begin : g_lo_pad
      assign lo_word = {{(DATA_W-LO_W){1'b0}}, cnt[LO_W-1:0]};
    end
  endgenerate

  assign hi_word = DATA_W'({run_q, shadow_q});

  always_comb begin
    run_d    = run_q;
    shadow_d = shadow_q;
    rdata_d  = '0;
    rvalid_d = 1'b0;
    unique case (acc)
      ACC_RD_LO: begin
        rdata_d  = lo_word;
        shadow_d = cnt[CNT_W-1 -: HI_W];
        rvalid_d = 1'b1;
      end
      ACC_RD_HI: begin
        rdata_d  = hi_word;
        rvalid_d = 1'b1;
      end
      ACC_RD_NONE: rvalid_d = 1'b1;
      ACC_WR_HI:   run_d    = wr_run;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      shadow_q <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      run_q    <= run_d;
      shadow_q <= shadow_d;
      rdata_q  <= rdata_d;
      rvalid_q <= rvalid_d;
    end
  end
endmodule

// File: rtl/tsc_timebase.sv
module tsc_timebase
  import tsc_pkg::*;
#(
  parameter int                ADDR_W = 8,
  parameter int                DATA_W = 32,
  parameter int                LO_W   = 32,
  parameter int                HI_W   = 8,
  parameter logic [ADDR_W-1:0] LO_OFF = 'h60,
  parameter logic [ADDR_W-1:0] HI_OFF = 'h64
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              tick,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid
);
  localparam int CNT_W = LO_W + HI_W;

  logic             rst_n;
  acc_e             acc;
  logic             run_q;
  logic [HI_W-1:0]  shadow_q;
  logic [CNT_W-1:0] cnt_q;
  logic             unused_wdata;

  assign unused_wdata = ^{bus_wdata[DATA_W-1:HI_W+1], bus_wdata[HI_W-1:0]};

  tsc_reset_sync u_rst (
    .clk    (clk),
    .arst_n (arst_n),
    .rst_n  (rst_n)
  );

  tsc_decode #(
    .ADDR_W (ADDR_W),
    .LO_OFF (LO_OFF),
    .HI_OFF (HI_OFF)
  ) u_dec (
    .rd   (bus_rd),
    .wr   (bus_wr),
    .addr (bus_addr),
    .acc  (acc)
  );

  tsc_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run_q),
    .tick  (tick),
    .cnt_q (cnt_q)
  );

  tsc_regs #(
    .DATA_W (DATA_W),
    .LO_W   (LO_W),
    .HI_W   (HI_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc      (acc),
    .wr_run   (bus_wdata[HI_W]),
    .cnt      (cnt_q),
    .run_q    (run_q),
    .shadow_q (shadow_q),
    .rdata_q  (bus_rdata),
    .rvalid_q (bus_rvalid)
  );
endmodule

// File: rtl/tsc_timebase_chk.sv
module tsc_timebase_chk #(
  parameter int                ADDR_W = 8,
  parameter int                DATA_W = 32,
  parameter int                LO_W   = 32,
  parameter int                HI_W   = 8,
  parameter logic [ADDR_W-1:0] LO_OFF = 'h60,
  parameter logic [ADDR_W-1:0] HI_OFF = 'h64,
  localparam int CNT_W = LO_W + HI_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_rvalid,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              run_q,
  input logic [HI_W-1:0]   shadow_q
);
  logic [LO_W-1:0] lo_now;
  logic [HI_W-1:0] top_now;
  logic            rd_lo, rd_hi, rd_other, wr_lo, wr_hi;

  assign lo_now   = cnt_q[LO_W-1:0];
  assign top_now  = cnt_q[CNT_W-1 -: HI_W];
  assign rd_lo    = bus_rd && bus_addr == LO_OFF;
  assign rd_hi    = bus_rd && bus_addr == HI_OFF;
  assign rd_other = bus_rd && bus_addr != LO_OFF && bus_addr != HI_OFF;
  assign wr_lo    = bus_wr && !bus_rd && bus_addr == LO_OFF;
  assign wr_hi    = bus_wr && !bus_rd && bus_addr == HI_OFF;

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(run_q && tick) |=> $stable(cnt_q));

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tick && !(&cnt_q)) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tick && (&cnt_q)) |=> cnt_q == '0);

  a_r4_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);

  a_r4_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> (!bus_rvalid && bus_rdata == '0));

  a_r4_lo_data: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo |=> bus_rdata == DATA_W'($past(lo_now)));

  a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo |=> shadow_q == $past(top_now));

  a_r6_hi_layout: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi |=> bus_rdata == DATA_W'({$past(run_q), $past(shadow_q)}));

  a_r7_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> (run_q == $past(bus_wdata[HI_W]) && $stable(shadow_q)));

  a_r8_low_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> ($stable(run_q) && $stable(shadow_q)));

  a_r9_old_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && tick && !run_q) |=> $stable(cnt_q));

  a_r10_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
    rd_other |=> (bus_rdata == '0 && $stable(shadow_q)));
endmodule

bind tsc_timebase tsc_timebase_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .LO_W   (LO_W),
  .HI_W   (HI_W),
  .LO_OFF (LO_OFF),
  .HI_OFF (HI_OFF)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .bus_rd     (bus_rd),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .cnt_q      (cnt_q),
  .run_q      (run_q),
  .shadow_q   (shadow_q)
);

// File: tb/tsc_timebase_tb.sv
module tsc_timebase_tb;
  localparam int LW = 6;
  localparam int HW = 8;
  localparam int CW = LW + HW;
  localparam logic [7:0] A_LO = 8'h60;
  localparam logic [7:0] A_HI = 8'h64;

  logic        clk = 1'b0;
  logic        arst_n, tick, rd, wr;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata;
  logic        rvalid;

  always #2 clk = ~clk;

  tsc_timebase #(.LO_W(LW), .HI_W(HW)) u_dut (
    .clk        (clk),
    .arst_n     (arst_n),
    .tick       (tick),
    .bus_rd     (rd),
    .bus_wr     (wr),
    .bus_addr   (addr),
    .bus_wdata  (wdata),
    .bus_rdata  (rdata),
    .bus_rvalid (rvalid)
  );

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;
  string cur_tag = "idle";

  logic [CW-1:0] m_cnt;
  logic          m_en;
  logic [HW-1:0] m_sh;
  logic [31:0]   exp_val_q[$];
  string         exp_tag_q[$];

  task automatic judge(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver side of the scoreboard: the requirement model predicts each read.
  always @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      m_cnt <= '0;
      m_en  <= 1'b0;
      m_sh  <= '0;
    end else begin
      if (rd) begin
        exp_tag_q.push_back(cur_tag);
        if (addr == A_LO) begin
          exp_val_q.push_back(32'(m_cnt[LW-1:0]));
          m_sh <= m_cnt[CW-1:LW];
        end else if (addr == A_HI) begin
          exp_val_q.push_back(32'({m_en, m_sh}));
        end else begin
          exp_val_q.push_back(32'h0);
        end
      end else if (wr && addr == A_HI) begin
        m_en <= wdata[8];
      end
      if (m_en && tick) m_cnt <= m_cnt + CW'(1);
    end
  end

  // Monitor side: compare every returned read with the oldest prediction.
  always @(negedge clk) begin
    if (arst_n && rvalid) begin
      if (exp_val_q.size() == 0) begin
        judge(1'b0, "R4 unexpected rvalid", rdata, 32'h0);
      end else begin
        logic [31:0] e;
        string       t;
        e = exp_val_q.pop_front();
        t = exp_tag_q.pop_front();
        judge(rdata === e, t, rdata, e);
      end
    end
  end

  task automatic cyc(bit r, bit w, logic [7:0] a, logic [31:0] d, bit tk, string tag);
    @(negedge clk);
    rd = r; wr = w; addr = a; wdata = d; tick = tk; cur_tag = tag;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 8'h00, 32'h0, 0, "idle");
  endtask

  task automatic run_ticks(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 8'h00, 32'h0, 1, "tick");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    judge(1'b0, "watchdog expired", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    arst_n = 1'b0; rd = 1'b0; wr = 1'b0; addr = '0; wdata = '0; tick = 1'b0;
    repeat (3) @(negedge clk);
    judge(rvalid === 1'b0, "R1 rvalid in reset", 32'(rvalid), 32'h0);
    judge(rdata === 32'h0, "R1 rdata in reset", rdata, 32'h0);
    arst_n = 1'b1;
    idle(4);

    // R1: count and high register read zero after reset
    cyc(1, 0, A_LO, 0, 0, "R1 low after reset");
    cyc(1, 0, A_HI, 0, 0, "R1 high after reset");
    idle(1);

    // R2: ticks while disabled do not count
    run_ticks(5);
    cyc(1, 0, A_LO, 0, 0, "R2 frozen while disabled");

    // R7: enable write ignores bits [7:0]
    cyc(0, 1, A_HI, 32'h0000_01FF, 0, "R7 enable write");
    cyc(1, 0, A_HI, 0, 0, "R7 enable readback");

    // R4: read latency of exactly one cycle
    cyc(1, 0, A_LO, 0, 0, "R4 low read");
    idle(1);
    judge(rvalid === 1'b1, "R4 rvalid after read", 32'(rvalid), 32'h1);
    idle(1);
    judge(rvalid === 1'b0, "R4 rvalid dropped", 32'(rvalid), 32'h0);

    // R2: counting, continuous then sparse
    run_ticks(10);
    cyc(1, 0, A_LO, 0, 0, "R2 ten ticks");
    for (int i = 0; i < 7; i++) begin
      cyc(0, 0, 8'h00, 0, 1, "tick");
      idle(2);
    end
    cyc(1, 0, A_LO, 0, 0, "R2 sparse ticks");

    // R9: enable write coinciding with a tick
    cyc(0, 1, A_HI, 32'h0, 1, "R9 disable with tick");
    run_ticks(3);
    cyc(1, 0, A_LO, 0, 0, "R9 tick counted under old enable");
    cyc(0, 1, A_HI, 32'h100, 1, "R9 enable with tick");
    cyc(1, 0, A_LO, 0, 0, "R9 tick dropped under old enable");

    // R8: low-word write is inert
    cyc(0, 1, A_LO, 32'hFFFF_FFFF, 1, "R8 low write");
    cyc(1, 0, A_LO, 0, 0, "R8 count after low write");
    cyc(1, 0, A_HI, 0, 0, "R8 high after low write");

    // R5: read collides with a carry out of the low word, twice
    for (int k = 0; k < 2; k++) begin
      idle(1);
      run_ticks(int'((2**LW) - 1) - int'(m_cnt[LW-1:0]));
      cyc(1, 0, A_LO, 0, 1, "R5 low read on carrying tick");
      cyc(1, 0, A_HI, 0, 0, "R5 high holds pre-carry byte");
      cyc(1, 0, A_LO, 0, 0, "R5 low after carry");
      cyc(1, 0, A_HI, 0, 0, "R5 high after recapture");
    end

    // R6: upper bits of the high register read zero
    cyc(0, 1, A_HI, 32'hFFFF_FFFF, 0, "R6 write all ones");
    cyc(1, 0, A_HI, 0, 0, "R6 high layout");

    // R10: other offsets read zero and leave the shadow alone
    run_ticks(70);
    cyc(1, 0, 8'h68, 0, 0, "R10 unmapped read");
    cyc(1, 0, 8'h61, 0, 0, "R10 unaligned read");
    cyc(1, 0, A_HI, 0, 0, "R10 shadow unchanged");

    // R3: wrap from all ones to zero
    idle(1);
    run_ticks(int'((2**CW) - 1) - int'(m_cnt));
    cyc(1, 0, A_LO, 0, 0, "R3 low at all ones");
    cyc(1, 0, A_HI, 0, 0, "R3 high at all ones");
    run_ticks(1);
    cyc(1, 0, A_LO, 0, 0, "R3 low after wrap");
    cyc(1, 0, A_HI, 0, 0, "R3 high after wrap");

    idle(4);
    judge(exp_val_q.size() == 0, "R4 reads left unanswered",
          32'(exp_val_q.size()), 32'h0);
    finish_run();
  end
endmodule